// File: doc/BRIEF.md
# Shared Message Buffer Memory with Two-Port Arbitration

This block holds the message buffers of a CAN controller in a single word memory that two masters share: a CPU port and the port of the CAN protocol engine. There are fifteen buffers of eight 16-bit words each. Each buffer holds one control/status word, two identifier words, four data words and one timestamp word. Both ports use the same word address space. Either port can read whole words and write single bytes or whole words through byte enables. When both ports target the memory in the same cycle, one of them is stalled with a wait signal and the grant alternates between them on every such cycle.

While the protocol engine owns a buffer, the buffer is busy. This covers the time a received frame is being copied into it and the time it is queued for sending. During that time the CPU may still read the whole buffer and may still write the byte that carries priority and status. Every other CPU write into that buffer is dropped, and a one-cycle violation pulse marks it. Addresses above the buffer area are decoded into a reserved gap, a control window and a reserved tail. The control window only raises a select strobe for a neighbouring register block.

Top module: `msgbuf_arbiter`

## Requirements
- R1: Word address 8*n+k (n = 0..14, k = 0..7) is word k of buffer n. Offsets are k=0 control/status, k=1,2 identifier, k=3..6 data, k=7 timestamp. A word written through one port reads back the same through either port.
- R2: A granted read presents the addressed word on that port's read data output after the next rising clock edge. The output holds its value on cycles without a read.
- R3: A port that requests while the other port does not target the buffer area (addresses 0..119) is never stalled. Its access completes in that cycle.
- R4: When both ports target the buffer area in the same cycle, exactly one port's wait output is low. The first such cycle after reset grants the CPU. Each later contention cycle grants the port that was not granted in the previous contention cycle.
- R5: Byte enable bit 0 writes data bits 7:0 and bit 1 writes bits 15:8. A lane whose enable is low keeps its stored value.
- R6: For a buffer whose busy input bit is high, CPU writes to offsets 1..7 and to bits 15:8 (data length code) of offset 0 are dropped. Such a dropped lane raises the violation output for exactly the one cycle after the write.
- R7: For a busy buffer, CPU writes to bits 7:0 of offset 0 (priority in bits 7:4, status in bits 3:0) take effect, and CPU reads are unaffected. Busy state never restricts the CAN port.
- R8: Addresses 120..127 and 142..255 are reserved. Reads there return 0 and writes there change nothing. Such accesses never stall.
- R9: Addresses 128..141 form the control window. A CPU request there drives the control-select output high in the same cycle. Through this block such accesses read 0, write nothing and never stall.
- R10: During reset, both read data outputs are 0 and the violation output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bufBusy | input | 15 | One bit per buffer, high while the protocol engine owns it |
| cpuReq | input | 1 | CPU access request |
| cpuWe | input | 1 | CPU write (1) or read (0) |
| cpuBe | input | 2 | CPU byte enables |
| cpuAddr | input | 8 | CPU word address |
| cpuWdata | input | 16 | CPU write data |
| cpuRdata | output | 16 | CPU read data, valid after the granted edge |
| cpuWait | output | 1 | CPU stalled this cycle; hold the request |
| cpuCtrlSel | output | 1 | CPU is addressing the control window |
| protViol | output | 1 | One-cycle pulse after a dropped CPU write lane |
| canReq | input | 1 | CAN engine access request |
| canWe | input | 1 | CAN engine write (1) or read (0) |
| canBe | input | 2 | CAN engine byte enables |
| canAddr | input | 8 | CAN engine word address |
| canWdata | input | 16 | CAN engine write data |
| canRdata | output | 16 | CAN engine read data |
| canWait | output | 1 | CAN engine stalled this cycle |

## Verification
The hardest situation to reach is a run of contention cycles that is interleaved with non-contention traffic. This is where the grant order has to carry across gaps. A second hard case is a busy buffer hit by a partial write at offset 0, where one lane lands and the other is dropped. The stimulus first fills every buffer word with a known value. It then drives held back-to-back contention and directed busy-buffer writes. Finally it runs a long random mix, biased toward the buffer area and with busy bits changing in slow epochs, so that contention, busy hits and reserved or control addresses occur together.

// File: rtl/msgbuf_pkg.sv
package msgbuf_pkg;
  localparam int DATA_W = 16;
  localparam int BE_W   = DATA_W / 8;

  // strobes from control to datapath for one cycle
  typedef struct packed {
    logic            useCan;   // memory port serves the CAN engine
    logic [BE_W-1:0] wrLane;   // lanes actually written (after protection)
    logic            cpuRd;    // granted CPU buffer read
    logic            canRd;    // granted CAN buffer read
    logic            cpuZero;  // CPU read outside the buffer area
    logic            canZero;  // CAN read outside the buffer area
  } memStrobeT;
endpackage

// File: rtl/msgbuf_ctrl.sv
module msgbuf_ctrl
  import msgbuf_pkg::*;
#(
  parameter int NUM_BUF    = 15,
  parameter int BUF_WORDS  = 8,
  parameter int RSV_WORDS  = 8,
  parameter int CTRL_WORDS = 14,
  parameter int ADDR_W     = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_BUF-1:0] bufBusy,
  input  logic              cpuReq,
  input  logic              cpuWe,
  input  logic [BE_W-1:0]   cpuBe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              canReq,
  input  logic              canWe,
  input  logic [BE_W-1:0]   canBe,
  input  logic [ADDR_W-1:0] canAddr,
  output logic              cpuWait,
  output logic              canWait,
  output logic              cpuCtrlSel,
  output logic              protViol,
  output memStrobeT         strobe
);
  localparam int BUF_AREA  = NUM_BUF * BUF_WORDS;
  localparam int OFF_W     = $clog2(BUF_WORDS);
  localparam int SLOT_W    = ADDR_W - OFF_W;
  localparam int CTRL_BASE = BUF_AREA + RSV_WORDS;
  localparam int CTRL_END  = CTRL_BASE + CTRL_WORDS;
  localparam logic [ADDR_W-1:0] BUF_LIM  = ADDR_W'(BUF_AREA);
  localparam logic [ADDR_W-1:0] CTRL_LO  = ADDR_W'(CTRL_BASE);
  localparam logic [ADDR_W-1:0] CTRL_HI  = ADDR_W'(CTRL_END);

  logic cpuInBuf, canInBuf, contend, turnCan;
  logic cpuGoBuf, canGoBuf, busyHit, offZero;
  logic [SLOT_W-1:0]  cpuSlot;
  logic [NUM_BUF-1:0] slotMatch;
  logic [BE_W-1:0]    allowLane, cpuLane, canLane;

  assign cpuInBuf = cpuAddr < BUF_LIM;
  assign canInBuf = canAddr < BUF_LIM;
  assign cpuSlot  = cpuAddr[ADDR_W-1:OFF_W];
  assign offZero  = cpuAddr[OFF_W-1:0] == '0;

  // one comparator per buffer selects its busy bit
  for (genvar i = 0; i < NUM_BUF; i++) begin : g_slot
    assign slotMatch[i] = cpuSlot == SLOT_W'(i);
  end
  assign busyHit = cpuInBuf && |(slotMatch & bufBusy);

  always_comb begin
    allowLane = '1;
    if (busyHit) begin
      allowLane    = '0;
      allowLane[0] = offZero;  // status/priority byte stays writable
    end
  end

  assign contend  = cpuReq && canReq && cpuInBuf && canInBuf;
  assign cpuWait  = contend && turnCan;
  assign canWait  = contend && !turnCan;
  assign cpuGoBuf = cpuReq && cpuInBuf && !cpuWait;
  assign canGoBuf = canReq && canInBuf && !canWait;

  assign cpuLane = (cpuGoBuf && cpuWe) ? (cpuBe & allowLane) : '0;
  assign canLane = (canGoBuf && canWe) ? canBe : '0;

  assign strobe.useCan  = canGoBuf;
  assign strobe.wrLane  = canGoBuf ? canLane : cpuLane;
  assign strobe.cpuRd   = cpuGoBuf && !cpuWe;
  assign strobe.canRd   = canGoBuf && !canWe;
  assign strobe.cpuZero = cpuReq && !cpuInBuf && !cpuWe;
  assign strobe.canZero = canReq && !canInBuf && !canWe;

  assign cpuCtrlSel = cpuReq && (cpuAddr >= CTRL_LO) && (cpuAddr < CTRL_HI);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      turnCan  <= 1'b0;
      protViol <= 1'b0;
    end else begin
      if (contend) turnCan <= !turnCan;
      protViol <= cpuGoBuf && cpuWe && |(cpuBe & ~allowLane);
    end
  end
endmodule

// File: rtl/msgbuf_dp.sv
module msgbuf_dp
  import msgbuf_pkg::*;
#(
  parameter int NUM_BUF   = 15,
  parameter int BUF_WORDS = 8,
  parameter int ADDR_W    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  memStrobeT         strobe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic [ADDR_W-1:0] canAddr,
  input  logic [DATA_W-1:0] canWdata,
  output logic [DATA_W-1:0] cpuRdata,
  output logic [DATA_W-1:0] canRdata
);
  localparam int BUF_AREA = NUM_BUF * BUF_WORDS;
  localparam int IDX_W    = $clog2(BUF_AREA);

  logic [DATA_W-1:0] mem [BUF_AREA];
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] wData, laneMask, merged;

  assign idx   = strobe.useCan ? canAddr[IDX_W-1:0] : cpuAddr[IDX_W-1:0];
  assign wData = strobe.useCan ? canWdata : cpuWdata;

  for (genvar g = 0; g < BE_W; g++) begin : g_lane
    assign laneMask[8*g +: 8] = {8{strobe.wrLane[g]}};
  end
  assign merged = (mem[idx] & ~laneMask) | (wData & laneMask);

  always_ff @(posedge clk) begin
    if (|strobe.wrLane) mem[idx] <= merged;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cpuRdata <= '0;
      canRdata <= '0;
    end else begin
      if (strobe.cpuRd)        cpuRdata <= mem[idx];
      else if (strobe.cpuZero) cpuRdata <= '0;
      if (strobe.canRd)        canRdata <= mem[idx];
      else if (strobe.canZero) canRdata <= '0;
    end
  end
endmodule

// File: rtl/msgbuf_arbiter.sv
module msgbuf_arbiter
  import msgbuf_pkg::*;
#(
  parameter int NUM_BUF    = 15,
  parameter int BUF_WORDS  = 8,
  parameter int RSV_WORDS  = 8,
  parameter int CTRL_WORDS = 14,
  parameter int ADDR_W     = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_BUF-1:0] bufBusy,
  input  logic               cpuReq,
  input  logic               cpuWe,
  input  logic [BE_W-1:0]    cpuBe,
  input  logic [ADDR_W-1:0]  cpuAddr,
  input  logic [DATA_W-1:0]  cpuWdata,
  output logic [DATA_W-1:0]  cpuRdata,
  output logic               cpuWait,
  output logic               cpuCtrlSel,
  output logic               protViol,
  input  logic               canReq,
  input  logic               canWe,
  input  logic [BE_W-1:0]    canBe,
  input  logic [ADDR_W-1:0]  canAddr,
  input  logic [DATA_W-1:0]  canWdata,
  output logic [DATA_W-1:0]  canRdata,
  output logic               canWait
);
  memStrobeT strobe;

  msgbuf_ctrl #(
    .NUM_BUF(NUM_BUF), .BUF_WORDS(BUF_WORDS), .RSV_WORDS(RSV_WORDS),
    .CTRL_WORDS(CTRL_WORDS), .ADDR_W(ADDR_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .bufBusy(bufBusy),
    .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuBe(cpuBe), .cpuAddr(cpuAddr),
    .canReq(canReq), .canWe(canWe), .canBe(canBe), .canAddr(canAddr),
    .cpuWait(cpuWait), .canWait(canWait), .cpuCtrlSel(cpuCtrlSel),
    .protViol(protViol), .strobe(strobe)
  );

  msgbuf_dp #(
    .NUM_BUF(NUM_BUF), .BUF_WORDS(BUF_WORDS), .ADDR_W(ADDR_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .cpuAddr(cpuAddr), .cpuWdata(cpuWdata),
    .canAddr(canAddr), .canWdata(canWdata),
    .cpuRdata(cpuRdata), .canRdata(canRdata)
  );
endmodule

// File: rtl/msgbuf_arbiter_chk.sv
module msgbuf_arbiter_chk #(
  parameter int NUM_BUF   = 15,
  parameter int BUF_WORDS = 8,
  parameter int ADDR_W    = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              cpuReq,
  input logic              cpuWe,
  input logic [ADDR_W-1:0] cpuAddr,
  input logic              canReq,
  input logic [ADDR_W-1:0] canAddr,
  input logic              cpuWait,
  input logic              canWait,
  input logic              protViol,
  input logic [15:0]       cpuRdata,
  input logic [15:0]       canRdata
);
  localparam logic [ADDR_W-1:0] BUF_LIM = ADDR_W'(NUM_BUF * BUF_WORDS);

  logic pastOk, bothIn;
  assign bothIn = cpuReq && canReq && (cpuAddr < BUF_LIM) && (canAddr < BUF_LIM);

  always_ff @(posedge clk) begin
    if (!rstN) pastOk <= 1'b0;
    else       pastOk <= 1'b1;
  end

  // R4: never both stalled
  a_r4_one_granted: assert property (@(posedge clk) disable iff (!rstN)
    !(cpuWait && canWait));

  // R4: consecutive contention alternates the grant
  a_r4_alternate: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && bothIn && $past(bothIn) && $past(!cpuWait)) |-> cpuWait);

  // R3: a lone request is not stalled
  a_r3_lone_cpu: assert property (@(posedge clk) disable iff (!rstN)
    (cpuReq && !canReq) |-> !cpuWait);

  // R8: accesses outside the buffer area never stall
  a_r8_out_nowait: assert property (@(posedge clk) disable iff (!rstN)
    (cpuReq && !(cpuAddr < BUF_LIM)) |-> !cpuWait);

  // R6: a violation pulse follows a granted CPU write and lasts one cycle
  a_r6_viol_cause: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && protViol) |-> $past(cpuReq && cpuWe && !cpuWait));
  a_r6_viol_pulse: assert property (@(posedge clk) disable iff (!rstN)
    protViol |=> !protViol || $past(cpuReq && cpuWe));

  // R10: reset state of the outputs
  a_r10_reset: assert property (@(posedge clk)
    !rstN |=> (cpuRdata == '0 && canRdata == '0 && !protViol));
endmodule

bind msgbuf_arbiter msgbuf_arbiter_chk #(
  .NUM_BUF(NUM_BUF), .BUF_WORDS(BUF_WORDS), .ADDR_W(ADDR_W)
) uChk (
  .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
  .canReq(canReq), .canAddr(canAddr), .cpuWait(cpuWait), .canWait(canWait),
  .protViol(protViol), .cpuRdata(cpuRdata), .canRdata(canRdata)
);

// File: tb/sim_msgbuf_arbiter.sv
`timescale 1ns/1ps
module sim_msgbuf_arbiter;
  logic        clk = 0, rstN = 0;
  logic [14:0] bufBusy = '0;
  logic        cpuReq = 0, cpuWe = 0, canReq = 0, canWe = 0;
  logic [1:0]  cpuBe = 0, canBe = 0;
  logic [7:0]  cpuAddr = 0, canAddr = 0;
  logic [15:0] cpuWdata = 0, canWdata = 0;
  logic [15:0] cpuRdata, canRdata;
  logic        cpuWait, canWait, cpuCtrlSel, protViol;

  msgbuf_arbiter u0 (
    .clk(clk), .rstN(rstN), .bufBusy(bufBusy),
    .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuBe(cpuBe), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .cpuRdata(cpuRdata), .cpuWait(cpuWait),
    .cpuCtrlSel(cpuCtrlSel), .protViol(protViol),
    .canReq(canReq), .canWe(canWe), .canBe(canBe), .canAddr(canAddr),
    .canWdata(canWdata), .canRdata(canRdata), .canWait(canWait)
  );

  always #10 clk = ~clk;

  int checks = 0, failures = 0;
  bit done = 0;

  logic [15:0] refMem [120];
  logic        refTurnCan = 0;
  logic [15:0] expCpuRd = 0, expCanRd = 0;
  string       cpuRdTag = "R10", canRdTag = "R10";

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] mergeLanes(logic [15:0] old, logic [15:0] d, logic [1:0] be);
    logic [15:0] m = {{8{be[1]}}, {8{be[0]}}};
    return (old & ~m) | (d & m);
  endfunction

  function automatic logic [1:0] cpuAllow(logic [7:0] a);
    if (a < 120 && bufBusy[a[7:3]]) return (a[2:0] == 0) ? 2'b01 : 2'b00;
    return 2'b11;
  endfunction

  function automatic string outTag(logic [7:0] a);
    if (a >= 128 && a < 142) return "R9";
    return "R8";
  endfunction

  // call at a negative edge; returns at the next negative edge
  task automatic step(logic cR, logic cW, logic [1:0] cB, logic [7:0] cA, logic [15:0] cD,
                      logic nR, logic nW, logic [1:0] nB, logic [7:0] nA, logic [15:0] nD);
    logic cont, eCw, eNw, cGo, nGo, eViol;
    logic [1:0] lane;
    cpuReq = cR; cpuWe = cW; cpuBe = cB; cpuAddr = cA; cpuWdata = cD;
    canReq = nR; canWe = nW; canBe = nB; canAddr = nA; canWdata = nD;
    #1;
    cont = cR && nR && cA < 120 && nA < 120;
    eCw = cont && refTurnCan;
    eNw = cont && !refTurnCan;
    chk(cont ? "R4" : "R3", "cpuWait", int'(cpuWait), int'(eCw));
    chk(cont ? "R4" : "R3", "canWait", int'(canWait), int'(eNw));
    chk("R9", "cpuCtrlSel", int'(cpuCtrlSel), int'(cR && cA >= 128 && cA < 142));
    cGo = cR && !eCw;
    nGo = nR && !eNw;
    lane = cpuAllow(cA);
    eViol = cGo && cW && cA < 120 && ((cB & ~lane) != 0);
    @(posedge clk);
    if (cGo && !cW) begin
      if (cA < 120) begin expCpuRd = refMem[cA]; cpuRdTag = "R2"; end
      else begin expCpuRd = 0; cpuRdTag = outTag(cA); end
    end
    if (nGo && !nW) begin
      if (nA < 120) begin expCanRd = refMem[nA]; canRdTag = "R2"; end
      else begin expCanRd = 0; canRdTag = outTag(nA); end
    end
    if (cGo && cW && cA < 120) refMem[cA] = mergeLanes(refMem[cA], cD, cB & lane);
    if (nGo && nW && nA < 120) refMem[nA] = mergeLanes(refMem[nA], nD, nB);
    if (cont) refTurnCan = !refTurnCan;
    @(negedge clk);
    chk(cpuRdTag, "cpuRdata", int'(cpuRdata), int'(expCpuRd));
    chk(canRdTag, "canRdata", int'(canRdata), int'(expCanRd));
    chk("R6", "protViol", int'(protViol), int'(eViol));
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd24601));
    repeat (3) @(negedge clk);
    chk("R10", "cpuRdata in reset", int'(cpuRdata), 0);
    chk("R10", "canRdata in reset", int'(canRdata), 0);
    chk("R10", "protViol in reset", int'(protViol), 0);
    rstN = 1;

    // fill every buffer word; R1 layout
    for (int w = 0; w < 120; w++)
      step(1, 1, 2'b11, 8'(w), 16'(w * 257) ^ 16'h5A3C, 0, 0, 0, 0, 0);

    // R1: timestamp of buffer 2 written by CAN, read by CPU
    step(0, 0, 0, 0, 0, 1, 1, 2'b11, 8'd23, 16'hBEEF);
    step(1, 0, 0, 8'd23, 0, 0, 0, 0, 0, 0);
    chk("R1", "buffer2 timestamp via cpu", int'(cpuRdata), 16'hBEEF);

    // R4: first contention goes to CPU, then alternates while held
    step(1, 0, 0, 8'd10, 0, 1, 0, 0, 8'd11, 0);
    chk("R4", "first contention cpu granted", int'(canRdata), 0);
    step(1, 0, 0, 8'd10, 0, 1, 0, 0, 8'd11, 0);
    chk("R4", "second contention can granted", int'(canRdata), int'(refMem[11]));
    step(1, 0, 0, 8'd12, 0, 1, 0, 0, 8'd13, 0);
    idle();
    step(1, 1, 2'b11, 8'd14, 16'h1111, 1, 1, 2'b11, 8'd15, 16'h2222);

    // R5: byte lanes
    step(1, 1, 2'b10, 8'd40, 16'hAB00, 0, 0, 0, 0, 0);
    step(1, 1, 2'b01, 8'd40, 16'h00CD, 0, 0, 0, 0, 0);
    step(1, 0, 0, 8'd40, 0, 0, 0, 0, 0, 0);
    chk("R5", "two byte writes merge", int'(cpuRdata), 16'hABCD);

    // R6 / R7: buffer 3 busy
    bufBusy = 15'h0008;
    step(1, 1, 2'b11, 8'd24, 16'h7777, 0, 0, 0, 0, 0);
    step(1, 0, 0, 8'd24, 0, 0, 0, 0, 0, 0);
    chk("R7", "status byte written, length code kept", int'(cpuRdata),
        int'({16'(24 * 257) ^ 16'h5A3C} & 16'hFF00 | 16'h0077));
    step(1, 1, 2'b11, 8'd27, 16'h0000, 0, 0, 0, 0, 0);
    step(1, 0, 0, 8'd27, 0, 0, 0, 0, 0, 0);
    chk("R6", "busy data word unchanged", int'(cpuRdata), int'(16'(27 * 257) ^ 16'h5A3C));
    step(0, 0, 0, 0, 0, 1, 1, 2'b11, 8'd27, 16'h4321);
    step(1, 0, 0, 8'd27, 0, 0, 0, 0, 0, 0);
    chk("R7", "can write to busy buffer", int'(cpuRdata), 16'h4321);
    bufBusy = '0;

    // R8 / R9: reserved and control window
    step(1, 1, 2'b11, 8'd125, 16'hFFFF, 0, 0, 0, 0, 0);
    step(1, 0, 0, 8'd125, 0, 1, 0, 0, 8'd125, 0);
    chk("R8", "reserved reads zero", int'(cpuRdata), 0);
    step(1, 0, 0, 8'd130, 0, 1, 0, 0, 8'd5, 0);
    chk("R9", "control window reads zero", int'(cpuRdata), 0);
    step(1, 1, 2'b11, 8'd200, 16'h1234, 1, 1, 2'b11, 8'd141, 16'h9999);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] ca, na;
      if (i % 64 == 0) bufBusy = 15'($urandom);
      ca = ($urandom_range(0, 9) < 8) ? 8'($urandom_range(0, 119)) : 8'($urandom);
      na = ($urandom_range(0, 9) < 8) ? 8'($urandom_range(0, 119)) : 8'($urandom);
      step(1'($urandom), 1'($urandom), 2'($urandom), ca, 16'($urandom),
           1'($urandom), 1'($urandom), 2'($urandom), na, 16'($urandom));
    end

    done = 1;
    summary();
    $finish;
  end
endmodule